// File: doc/BRIEF.md
# Trap Entry State Save Unit

This block performs the bookkeeping of a processor trap entry in a single clock edge. When the caller pulses `trap_go`, it takes the current architectural state presented on its inputs, raises the trap level by one and stores the pre-trap context in a per-level trap stack. The stored context for each level is a packed state word, the return PC and NPC, the full pre-trap hyper-state word and the trap type.

In the same edge it computes the post-trap privileged state, hyper-state, global level and window pointer, and holds them on registered outputs. The `trap_kind` input selects one of three destinations: privileged, hyperprivileged or reset-error. Each destination has its own rule for updating the state words and for the global-level ceiling. The window pointer moves by a rule keyed on the trap type and wraps modulo the window count.

A combinational read port returns the stacked context of any trap level, so the stack can be inspected. Vector address generation and instruction fetch belong to other blocks.

Top module: `trap_entry_unit`

## Requirements
- R1: After reset, all `new_*` outputs are zero, and every stack level reads back as zero.
- R2: A pulse with `cur_tl < MAX_TL` sets `new_tl` to `cur_tl+1` and writes the stack entry at level `cur_tl+1`. A pulse with `cur_tl == MAX_TL` is dropped: no output and no stack entry changes.
- R3: The stored state word is 43 bits. It holds the global level in bits 42:40, CCR in 39:32, ASI in 31:24, the 13-bit privileged state in 20:8 and the window pointer in 4:0. All other bits are zero.
- R4: The stored PC and NPC equal the current values. When privileged-state bit 3 is set, both are cut to their low 32 bits. The stored hyper-state is the full pre-trap hyper-state, and the stored trap type is the input type.
- R5: The new global level is `min(cur_gl+1, MAX_PGL)` for privileged entry. For the other kinds it is `min(cur_gl+1, MAX_GL)`.
- R6: Privileged entry (`trap_kind` 0) sets privileged-state bits 4 and 2, clears bits 3 and 1, and copies bit 8 into bit 9. The hyper-state is left unchanged.
- R7: Hyperprivileged entry (`trap_kind` 1) sets privileged-state bit 4 and clears bits 3, 1 and 9. In the hyper-state it clears bits 5 and 10, sets bit 2 and keeps bit 0.
- R8: Reset-error entry (`trap_kind` 2 or 3) keeps only bit 2 of the privileged state and sets bit 4. In the hyper-state it sets bits 5 and 2 and clears bits 10 and 0.
- R9: The new window pointer is computed from the trap type. Type 0x24 adds 1. Types 0x80 to 0xBF add `cur_cansave+2`. Types 0xC0 to 0xFF subtract 1. In each of these cases the result is taken modulo `NWIN`. Every other type passes `cur_cwp` through unchanged.
- R10: While `trap_go` is low, all `new_*` outputs and the stack hold their values, whatever the other inputs do.
- R11: A read of level 0, or of a level above `MAX_TL`, returns zero on every read output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| trap_go | input | 1 | Trap entry pulse |
| trap_kind | input | 2 | 0 privileged, 1 hyperprivileged, 2/3 reset-error |
| trap_type | input | 9 | Trap type |
| cur_pc | input | PC_W | Current PC |
| cur_npc | input | PC_W | Current next PC |
| cur_ccr | input | 8 | Condition codes |
| cur_asi | input | 8 | Address space identifier |
| cur_cwp | input | CWW | Current window pointer |
| cur_cansave | input | CWW | Savable window count |
| cur_gl | input | GLW | Current global level |
| cur_pstate | input | 13 | Privileged state word |
| cur_hpstate | input | 11 | Hyper-state word |
| cur_tl | input | TLW | Current trap level |
| new_tl | output | TLW | Trap level after entry |
| new_gl | output | GLW | Global level after entry |
| new_cwp | output | CWW | Window pointer after entry |
| new_pstate | output | 13 | Privileged state after entry |
| new_hpstate | output | 11 | Hyper-state after entry |
| rd_lvl | input | TLW | Stack level to read |
| rd_tstate | output | 43 | Stored state word |
| rd_tpc | output | PC_W | Stored PC |
| rd_tnpc | output | PC_W | Stored NPC |
| rd_htstate | output | 11 | Stored hyper-state |
| rd_tt | output | 9 | Stored trap type |

## Verification
The bench builds the block with `NWIN=6`, `MAX_TL=4`, `MAX_GL=3` and `MAX_PGL=2`. A window count that is not a power of two makes the modulo wrap visible in all three directions; a two-bit wrap would hide an error here. The small trap-level limit lets the dropped-entry case at the top of the stack be reached. It also lets the read port be probed one level past the end. The gap between the two global-level ceilings separates privileged saturation from the other kinds.

// File: rtl/trap_entry_unit.sv
module trap_entry_unit #(
  parameter int NWIN    = 8,
  parameter int MAX_TL  = 6,
  parameter int MAX_GL  = 3,
  parameter int MAX_PGL = 2,
  parameter int PC_W    = 64,
  localparam int CWW = $clog2(NWIN),
  localparam int TLW = $clog2(MAX_TL + 2),
  localparam int GLW = $clog2(MAX_GL + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            trap_go,
  input  logic [1:0]      trap_kind,
  input  logic [8:0]      trap_type,
  input  logic [PC_W-1:0] cur_pc,
  input  logic [PC_W-1:0] cur_npc,
  input  logic [7:0]      cur_ccr,
  input  logic [7:0]      cur_asi,
  input  logic [CWW-1:0]  cur_cwp,
  input  logic [CWW-1:0]  cur_cansave,
  input  logic [GLW-1:0]  cur_gl,
  input  logic [12:0]     cur_pstate,
  input  logic [10:0]     cur_hpstate,
  input  logic [TLW-1:0]  cur_tl,
  output logic [TLW-1:0]  new_tl,
  output logic [GLW-1:0]  new_gl,
  output logic [CWW-1:0]  new_cwp,
  output logic [12:0]     new_pstate,
  output logic [10:0]     new_hpstate,
  input  logic [TLW-1:0]  rd_lvl,
  output logic [42:0]     rd_tstate,
  output logic [PC_W-1:0] rd_tpc,
  output logic [PC_W-1:0] rd_tnpc,
  output logic [10:0]     rd_htstate,
  output logic [8:0]      rd_tt
);

  logic [42:0]     stk_ts [1:MAX_TL];
  logic [PC_W-1:0] stk_pc [1:MAX_TL];
  logic [PC_W-1:0] stk_np [1:MAX_TL];
  logic [10:0]     stk_hs [1:MAX_TL];
  logic [8:0]      stk_tt [1:MAX_TL];

  logic is_red, is_hyp, take;
  assign is_red = trap_kind[1];
  assign is_hyp = (trap_kind == 2'd1);
  assign take   = trap_go && (int'(cur_tl) < MAX_TL);

  logic [PC_W-1:0] pc_s, npc_s;
  assign pc_s  = cur_pstate[3] ? {{(PC_W-32){1'b0}}, cur_pc[31:0]}  : cur_pc;
  assign npc_s = cur_pstate[3] ? {{(PC_W-32){1'b0}}, cur_npc[31:0]} : cur_npc;

  logic [42:0] ts_w;
  assign ts_w = {3'(cur_gl), cur_ccr, cur_asi, 3'b000, cur_pstate, 3'b000, 5'(cur_cwp)};

  logic [GLW-1:0] gl_n;
  logic [CWW-1:0] cwp_n;
  logic [12:0]    ps_n;
  logic [10:0]    hp_n;

  always_comb begin
    int lim, g, c;
    lim = (is_red || is_hyp) ? MAX_GL : MAX_PGL;
    g = int'(cur_gl) + 1;
    gl_n = GLW'((g > lim) ? lim : g);

    c = int'(cur_cwp);
    if (trap_type == 9'h024)            c = (c + 1) % NWIN;
    else if (trap_type[8:6] == 3'b010)  c = (c + int'(cur_cansave) + 2) % NWIN;
    else if (trap_type[8:6] == 3'b011)  c = (c + NWIN - 1) % NWIN;
    cwp_n = CWW'(c);

    ps_n = cur_pstate;
    hp_n = cur_hpstate;
    if (is_red) begin
      ps_n = (cur_pstate & 13'h004) | 13'h010;
      hp_n[5] = 1'b1; hp_n[2] = 1'b1; hp_n[10] = 1'b0; hp_n[0] = 1'b0;
    end else begin
      ps_n[4] = 1'b1; ps_n[3] = 1'b0; ps_n[1] = 1'b0;
      if (is_hyp) begin
        ps_n[9] = 1'b0;
        hp_n[5] = 1'b0; hp_n[2] = 1'b1; hp_n[10] = 1'b0;
      end else begin
        ps_n[2] = 1'b1;
        ps_n[9] = cur_pstate[8];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      new_tl <= '0; new_gl <= '0; new_cwp <= '0;
      new_pstate <= '0; new_hpstate <= '0;
      for (int i = 1; i <= MAX_TL; i++) begin
        stk_ts[i] <= '0; stk_pc[i] <= '0; stk_np[i] <= '0;
        stk_hs[i] <= '0; stk_tt[i] <= '0;
      end
    end else if (take) begin
      new_tl      <= cur_tl + 1'b1;
      new_gl      <= gl_n;
      new_cwp     <= cwp_n;
      new_pstate  <= ps_n;
      new_hpstate <= hp_n;
      for (int i = 1; i <= MAX_TL; i++) begin
        if (int'(cur_tl) + 1 == i) begin
          stk_ts[i] <= ts_w;
          stk_pc[i] <= pc_s;
          stk_np[i] <= npc_s;
          stk_hs[i] <= cur_hpstate;
          stk_tt[i] <= trap_type;
        end
      end
    end
  end

  always_comb begin
    rd_tstate = '0; rd_tpc = '0; rd_tnpc = '0; rd_htstate = '0; rd_tt = '0;
    for (int i = 1; i <= MAX_TL; i++) begin
      if (int'(rd_lvl) == i) begin
        rd_tstate  = stk_ts[i];
        rd_tpc     = stk_pc[i];
        rd_tnpc    = stk_np[i];
        rd_htstate = stk_hs[i];
        rd_tt      = stk_tt[i];
      end
    end
  end

endmodule

// File: rtl/trap_entry_chk.sv
module trap_entry_chk #(
  parameter int NWIN = 8, MAX_TL = 6, MAX_GL = 3, MAX_PGL = 2,
  parameter int CWW = 3, TLW = 3, GLW = 2
) (
  input logic           clk,
  input logic           rst_n,
  input logic           trap_go,
  input logic [1:0]     trap_kind,
  input logic [TLW-1:0] cur_tl,
  input logic [TLW-1:0] new_tl,
  input logic [GLW-1:0] new_gl,
  input logic [CWW-1:0] new_cwp,
  input logic [12:0]    new_pstate,
  input logic [10:0]    new_hpstate
);

  p_tl_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_go && int'(cur_tl) < MAX_TL) |=> (new_tl == $past(cur_tl) + 1'b1));

  p_tl_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_go && int'(cur_tl) >= MAX_TL) |=> ($stable(new_tl) && $stable(new_pstate)));

  p_gl_cap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    int'(new_gl) <= MAX_GL);

  p_cwp_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_go && int'(cur_tl) < MAX_TL) |=> int'(new_cwp) < NWIN);

  p_red_hp_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_go && trap_kind[1] && int'(cur_tl) < MAX_TL) |=>
      (new_hpstate[5] && new_hpstate[2] && !new_hpstate[0] && !new_hpstate[10] && new_pstate[4]));

  p_hyp_ps_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_go && trap_kind == 2'd1 && int'(cur_tl) < MAX_TL) |=>
      (!new_pstate[9] && !new_pstate[3] && !new_pstate[1] && !new_hpstate[5] && new_hpstate[2]));

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !trap_go |=> ($stable(new_tl) && $stable(new_gl) && $stable(new_cwp)
                  && $stable(new_pstate) && $stable(new_hpstate)));

endmodule

bind trap_entry_unit trap_entry_chk #(
  .NWIN(NWIN), .MAX_TL(MAX_TL), .MAX_GL(MAX_GL), .MAX_PGL(MAX_PGL),
  .CWW(CWW), .TLW(TLW), .GLW(GLW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .trap_go(trap_go), .trap_kind(trap_kind),
  .cur_tl(cur_tl), .new_tl(new_tl), .new_gl(new_gl), .new_cwp(new_cwp),
  .new_pstate(new_pstate), .new_hpstate(new_hpstate)
);

// File: tb/tb_trap_entry_unit.sv
module tb_trap_entry_unit;
  localparam int CLK_PERIOD = 10;
  localparam int NWIN = 6, MAX_TL = 4, MAX_GL = 3, MAX_PGL = 2, PC_W = 64;
  localparam int CWW = $clog2(NWIN), TLW = $clog2(MAX_TL + 2), GLW = $clog2(MAX_GL + 1);

  logic clk = 0, rst_n = 0, trap_go = 0;
  logic [1:0] trap_kind = 0;
  logic [8:0] trap_type = 0;
  logic [PC_W-1:0] cur_pc = 0, cur_npc = 0;
  logic [7:0] cur_ccr = 0, cur_asi = 0;
  logic [CWW-1:0] cur_cwp = 0, cur_cansave = 0;
  logic [GLW-1:0] cur_gl = 0;
  logic [12:0] cur_pstate = 0;
  logic [10:0] cur_hpstate = 0;
  logic [TLW-1:0] cur_tl = 0, rd_lvl = 0;
  logic [TLW-1:0] new_tl;
  logic [GLW-1:0] new_gl;
  logic [CWW-1:0] new_cwp;
  logic [12:0] new_pstate;
  logic [10:0] new_hpstate, rd_htstate;
  logic [42:0] rd_tstate;
  logic [PC_W-1:0] rd_tpc, rd_tnpc;
  logic [8:0] rd_tt;

  int errors = 0, checks = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  trap_entry_unit #(.NWIN(NWIN), .MAX_TL(MAX_TL), .MAX_GL(MAX_GL), .MAX_PGL(MAX_PGL), .PC_W(PC_W)) dut (
    .clk(clk), .rst_n(rst_n), .trap_go(trap_go), .trap_kind(trap_kind), .trap_type(trap_type),
    .cur_pc(cur_pc), .cur_npc(cur_npc), .cur_ccr(cur_ccr), .cur_asi(cur_asi),
    .cur_cwp(cur_cwp), .cur_cansave(cur_cansave), .cur_gl(cur_gl), .cur_pstate(cur_pstate),
    .cur_hpstate(cur_hpstate), .cur_tl(cur_tl), .new_tl(new_tl), .new_gl(new_gl),
    .new_cwp(new_cwp), .new_pstate(new_pstate), .new_hpstate(new_hpstate), .rd_lvl(rd_lvl),
    .rd_tstate(rd_tstate), .rd_tpc(rd_tpc), .rd_tnpc(rd_tnpc), .rd_htstate(rd_htstate), .rd_tt(rd_tt));

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [12:0] e_ps(input logic [1:0] k, input logic [12:0] p);
    logic [12:0] r;
    if (k[1]) return (p & 13'h004) | 13'h010;
    r = p | 13'h010; r[3] = 0; r[1] = 0;
    if (k == 2'd1) r[9] = 0;
    else begin r[2] = 1; r[9] = p[8]; end
    return r;
  endfunction

  function automatic logic [10:0] e_hp(input logic [1:0] k, input logic [10:0] h);
    logic [10:0] r;
    r = h;
    if (k[1]) begin r[5] = 1; r[2] = 1; r[10] = 0; r[0] = 0; end
    else if (k == 2'd1) begin r[5] = 0; r[2] = 1; r[10] = 0; end
    return r;
  endfunction

  function automatic int e_gl(input logic [1:0] k, input int g);
    int lim;
    lim = (k == 2'd0) ? MAX_PGL : MAX_GL;
    return (g + 1 > lim) ? lim : g + 1;
  endfunction

  function automatic int e_cwp(input int tt, input int c, input int cs);
    if (tt == 'h24) return (c + 1) % NWIN;
    if (tt >= 'h80 && tt <= 'hBF) return (c + cs + 2) % NWIN;
    if (tt >= 'hC0 && tt <= 'hFF) return (c + NWIN - 1) % NWIN;
    return c;
  endfunction

  function automatic logic [42:0] e_ts(input int g, input logic [7:0] cc, input logic [7:0] as,
                                       input logic [12:0] p, input int c);
    logic [42:0] r;
    r = '0;
    r[42:40] = 3'(g); r[39:32] = cc; r[31:24] = as; r[20:8] = p; r[4:0] = 5'(c);
    return r;
  endfunction

  task automatic do_trap(input logic [1:0] k, input logic [8:0] tt, input int tl, input int gl,
                         input int cwp, input int cs, input logic [12:0] ps, input logic [10:0] hp,
                         input logic [63:0] pc, input logic [63:0] npc);
    logic [63:0] epc, enpc;
    logic [7:0] cc, as;
    cc = 8'($urandom); as = 8'($urandom);
    @(negedge clk);
    trap_kind = k; trap_type = tt; cur_tl = TLW'(tl); cur_gl = GLW'(gl);
    cur_cwp = CWW'(cwp); cur_cansave = CWW'(cs); cur_pstate = ps; cur_hpstate = hp;
    cur_pc = pc; cur_npc = npc; cur_ccr = cc; cur_asi = as; trap_go = 1;
    @(negedge clk);
    trap_go = 0;
    rd_lvl = TLW'(tl + 1);
    #1;
    epc = ps[3] ? {32'b0, pc[31:0]} : pc;
    enpc = ps[3] ? {32'b0, npc[31:0]} : npc;
    check("R2 new_tl", 64'(new_tl), 64'(tl + 1));
    check("R5 new_gl", 64'(new_gl), 64'(e_gl(k, gl)));
    check("R9 new_cwp", 64'(new_cwp), 64'(e_cwp(int'(tt), cwp, cs)));
    check(k[1] ? "R8 pstate" : (k == 1 ? "R7 pstate" : "R6 pstate"), 64'(new_pstate), 64'(e_ps(k, ps)));
    check(k[1] ? "R8 hpstate" : (k == 1 ? "R7 hpstate" : "R6 hpstate"), 64'(new_hpstate), 64'(e_hp(k, hp)));
    check("R3 tstate", 64'(rd_tstate), 64'(e_ts(gl, cc, as, ps, cwp)));
    check("R4 tpc", rd_tpc, epc);
    check("R4 tnpc", rd_tnpc, enpc);
    check("R4 htstate", 64'(rd_htstate), 64'(hp));
    check("R4 tt", 64'(rd_tt), 64'(tt));
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [TLW-1:0] s_tl; logic [GLW-1:0] s_gl; logic [CWW-1:0] s_cwp;
    logic [12:0] s_ps; logic [10:0] s_hp; logic [42:0] s_ts; logic [63:0] s_pc;
    void'($urandom(32'h5a17));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check("R1 new_tl", 64'(new_tl), 0);
    check("R1 new_pstate", 64'(new_pstate), 0);
    check("R1 new_hpstate", 64'(new_hpstate), 0);
    for (int l = 1; l <= MAX_TL; l++) begin
      rd_lvl = TLW'(l); #1;
      check("R1 stack", 64'(rd_tstate) | rd_tpc | rd_tnpc | 64'(rd_tt), 0);
    end

    // R9 window pointer corners (NWIN=6)
    do_trap(2'd0, 9'h024, 0, 0, 5, 0, 13'h000, 11'h000, 64'h10, 64'h14);
    do_trap(2'd0, 9'h080, 1, 1, 4, 5, 13'h100, 11'h001, 64'h20, 64'h24);
    do_trap(2'd1, 9'h0BF, 2, 1, 5, 5, 13'h3FF, 11'h7FF, 64'h30, 64'h34);
    do_trap(2'd0, 9'h0C0, 0, 0, 0, 2, 13'h000, 11'h000, 64'h40, 64'h44);
    do_trap(2'd2, 9'h0FF, 3, 2, 3, 1, 13'h1FFF, 11'h7FF, 64'h50, 64'h54);
    do_trap(2'd0, 9'h025, 0, 0, 3, 4, 13'h000, 11'h000, 64'h60, 64'h64);
    do_trap(2'd1, 9'h100, 0, 0, 2, 4, 13'h000, 11'h000, 64'h70, 64'h74);
    // R4 address-mask truncation
    do_trap(2'd0, 9'h030, 1, 0, 1, 0, 13'h008, 11'h000, 64'hDEAD_BEEF_1234_5678, 64'hCAFE_0000_8765_4321);
    // R5 saturation on both ceilings
    do_trap(2'd0, 9'h031, 0, 2, 0, 0, 13'h000, 11'h000, 64'h80, 64'h84);
    do_trap(2'd0, 9'h031, 0, 3, 0, 0, 13'h000, 11'h000, 64'h80, 64'h84);
    do_trap(2'd1, 9'h031, 0, 2, 0, 0, 13'h000, 11'h000, 64'h80, 64'h84);
    do_trap(2'd3, 9'h031, 0, 3, 0, 0, 13'h104, 11'h421, 64'h80, 64'h84);
    // R6/R7 bit 8 copy versus clear
    do_trap(2'd0, 9'h011, 2, 0, 0, 0, 13'h10A, 11'h425, 64'h90, 64'h94);
    do_trap(2'd1, 9'h011, 2, 0, 0, 0, 13'h30A, 11'h421, 64'h90, 64'h94);

    // random mix
    for (int n = 0; n < 60; n++) begin
      do_trap(2'($urandom), 9'($urandom), int'($urandom % MAX_TL), int'($urandom % (MAX_GL + 1)),
              int'($urandom % NWIN), int'($urandom % NWIN), 13'($urandom), 11'($urandom),
              {$urandom, $urandom}, {$urandom, $urandom});
    end

    // R2 dropped entry at the top level and R10 hold
    do_trap(2'd0, 9'h050, MAX_TL - 1, 1, 2, 1, 13'h0F0, 11'h0AA, 64'hA0, 64'hA4);
    s_tl = new_tl; s_gl = new_gl; s_cwp = new_cwp; s_ps = new_pstate; s_hp = new_hpstate;
    rd_lvl = TLW'(MAX_TL); #1; s_ts = rd_tstate; s_pc = rd_tpc;
    @(negedge clk);
    trap_kind = 2'd2; trap_type = 9'h024; cur_tl = TLW'(MAX_TL); cur_pc = 64'h1;
    cur_pstate = 13'h1FFF; cur_hpstate = 11'h7FF; cur_gl = 0; trap_go = 1;
    @(negedge clk);
    trap_go = 0; #1;
    check("R2 drop tl", 64'(new_tl), 64'(s_tl));
    check("R2 drop pstate", 64'(new_pstate), 64'(s_ps));
    check("R2 drop hpstate", 64'(new_hpstate), 64'(s_hp));
    check("R2 drop stack", 64'(rd_tstate), 64'(s_ts));
    check("R2 drop tpc", rd_tpc, s_pc);
    cur_tl = 0; trap_kind = 2'd1; trap_type = 9'h0C5; cur_gl = 3;
    repeat (3) @(negedge clk);
    #1;
    check("R10 hold tl", 64'(new_tl), 64'(s_tl));
    check("R10 hold gl", 64'(new_gl), 64'(s_gl));
    check("R10 hold cwp", 64'(new_cwp), 64'(s_cwp));
    check("R10 hold pstate", 64'(new_pstate), 64'(s_ps));
    check("R10 hold stack", 64'(rd_tstate), 64'(s_ts));

    // R11 out-of-range reads
    rd_lvl = 0; #1;
    check("R11 level0", 64'(rd_tstate) | rd_tpc | rd_tnpc | 64'(rd_htstate) | 64'(rd_tt), 0);
    rd_lvl = TLW'(MAX_TL + 1); #1;
    check("R11 above", 64'(rd_tstate) | rd_tpc | rd_tnpc | 64'(rd_htstate) | 64'(rd_tt), 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule